// File: doc/BRIEF.md
# Character Attribute and Flash Renderer

This block sits in the pixel path of an on-screen display overlay. For every pixel it takes the dot bit fetched from the glyph, two flags saying whether the pixel lies inside a character cell or inside the display frame, and the two attribute bits stored with the current cell. From these it picks one output level code for the analog stage that follows. The codes are: pass the incoming video, character (bright or dim), blanking (dark or grey), halftone, or background.

Reverse video swaps glyph and background dots inside a cell. The second attribute bit means either highlight or flashing, chosen by one global control bit. A blink timer counts vertical sync pulses and sets the flash phase, with a fast or slow period and an equal on and off time. A 2-bit mode sets the blanking area. A per-row mask, loaded in two halves, enables halftone on selected rows. A master display enable suppresses all character dots. The code is registered, so it appears one clock after the pixel inputs.

Top module: `osd_cell_shader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the level code is PASS (0). The halftone mask is all zero. The flash phase is "on".
- R2: A pixel with `in_cell_i`=1 and `dot_i`=1, no attributes and the display on gives CHAR_HI (1), or CHAR_LO (2) when `char_dim_i`=1. The code appears on `level_o` one clock after the inputs. Any pixel outside a cell, with nothing else active, gives PASS (0).
- R3: With `attr_rev_i`=1 inside a cell, glyph dots become non-dots and cell background pixels become character dots. Outside a cell, `attr_rev_i` has no effect.
- R4: The flash phase starts "on". It toggles after every 15th rising edge of `vsync_i` when `flash_slow_i`=0, and after every 30th rising edge when it is 1. This gives about 0.5 s and 1.0 s periods at 60 fields per second, with a 50% duty cycle.
- R5: With `attr_hf_i`=1 and `hf_flash_i`=1, a cell shows its dots normally during the on phase. During the off phase its dots take the level the pixel would have as a non-dot: blanking, halftone, background or PASS.
- R6: With `attr_hf_i`=1 and `hf_flash_i`=0 (highlight), the cell's dots stay at character level. Its non-dot pixels take the blanking level whatever the blanking mode. The flash phase has no effect on such a cell.
- R7: Blanking mode 0 blanks nothing. Mode 1 blanks non-dot pixels with `in_cell_i`=1. Mode 2 blanks non-dot pixels with `in_frame_i`=1. Mode 3 blanks every non-dot pixel.
- R8: The blanking level is BLANK_LO (3), or BLANK_HI (4) when `blank_grey_i`=1.
- R9: With `disp_on_i`=0 no pixel gives CHAR_HI or CHAR_LO. Blanking, halftone and background still apply.
- R10: A write with `half_wr_i`=1 loads `half_data_i` into mask rows 0-5 when `half_hi_i`=0, or rows 6-11 when it is 1. Data bit k goes to row k or row 6+k, and the other half is left unchanged. A non-dot, non-blanked pixel with `in_frame_i`=1 on a masked row gives HALF (5). Rows 12-15 never give HALF.
- R11: With `bg_on_i`=1, a pixel that would otherwise be PASS gives BGND (6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_i | input | 1 | Vertical sync; rising edges clock the blink timer |
| dot_i | input | 1 | Glyph dot of the current pixel |
| in_cell_i | input | 1 | Pixel lies inside a character cell |
| in_frame_i | input | 1 | Pixel lies inside the display frame |
| row_i | input | 4 | Character row index of the pixel (0-11 valid) |
| attr_rev_i | input | 1 | Cell attribute: reverse video |
| attr_hf_i | input | 1 | Cell attribute: highlight or flash |
| disp_on_i | input | 1 | Master character display enable |
| hf_flash_i | input | 1 | Global: 1 = attribute 2 flashes, 0 = highlights |
| flash_slow_i | input | 1 | Global: 1 = slow flash period |
| blank_mode_i | input | 2 | Blanking area mode 0-3 |
| char_dim_i | input | 1 | Character intensity select (1 = dim) |
| blank_grey_i | input | 1 | Blanking intensity select (1 = grey) |
| bg_on_i | input | 1 | Background fill enable |
| half_wr_i | input | 1 | Halftone mask write strobe |
| half_hi_i | input | 1 | Halftone half select (1 = rows 6-11) |
| half_data_i | input | 6 | Halftone mask half data |
| level_o | output | 3 | Registered level code |

## Verification
The hardest case to reach is the flash off phase. It appears only after 15 or 30 counted field edges, and the slow period must be shown to differ from the fast one on exactly the edge where they part. The stimulus resets the timer, then issues a counted train of short vsync pulses. It checks the flashing pixel one pulse before and one pulse after the expected toggle, both with blanking off and with cell blanking on, so the dot is seen falling to PASS and to the blanking level.

// File: rtl/osd_shade_pkg.sv
package osd_shade_pkg;
    typedef enum logic [2:0] {
        LVL_PASS     = 3'd0,
        LVL_CHAR_HI  = 3'd1,
        LVL_CHAR_LO  = 3'd2,
        LVL_BLANK_LO = 3'd3,
        LVL_BLANK_HI = 3'd4,
        LVL_HALF     = 3'd5,
        LVL_BGND     = 3'd6
    } lvl_e;
endpackage

// File: rtl/osd_flash_timer.sv
module osd_flash_timer #(
    parameter int FAST_FIELDS = 15,
    parameter int SLOW_FIELDS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    input  logic slow_i,
    output logic phase_o
);
    localparam int CNT_W = $clog2(SLOW_FIELDS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic             vs;
    } tmr_t;

    tmr_t st_d, st_q;
    logic edge_w;
    logic [CNT_W-1:0] limit_w;

    always_comb begin
        st_d    = st_q;
        st_d.vs = vsync_i;
        edge_w  = vsync_i & ~st_q.vs;
        limit_w = slow_i ? CNT_W'(SLOW_FIELDS - 1) : CNT_W'(FAST_FIELDS - 1);
        if (edge_w) begin
            if (st_q.cnt >= limit_w) begin
                st_d.cnt   = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.phase <= 1'b1;
            st_q.vs    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(SLOW_FIELDS))
        else $error("R4 blink counter out of range");

    a_r4_phase_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.phase) |-> $past(edge_w))
        else $error("R4 flash phase moved without a field edge");
endmodule

// File: rtl/osd_halftone_mask.sv
module osd_halftone_mask #(
    parameter int ROWS  = 12,
    parameter int ROW_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               hi_i,
    input  logic [ROWS/2-1:0]  data_i,
    input  logic [ROW_W-1:0]   row_i,
    output logic               half_o
);
    localparam int HALF = ROWS / 2;

    typedef struct packed {
        logic [ROWS-1:0] mask;
    } msk_t;

    msk_t st_d, st_q;
    logic [ROWS-1:0] shifted_w;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (hi_i) st_d.mask[ROWS-1:HALF] = data_i;
            else      st_d.mask[HALF-1:0]    = data_i;
        end
        shifted_w = st_q.mask >> row_i;
        half_o    = (int'(row_i) < ROWS) && shifted_w[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_i)) |-> $stable(st_q.mask))
        else $error("R10 halftone mask changed without a write");
endmodule

// File: rtl/osd_pixel_resolve.sv
module osd_pixel_resolve
    import osd_shade_pkg::*;
(
    input  logic       dot_i,
    input  logic       in_cell_i,
    input  logic       in_frame_i,
    input  logic       attr_rev_i,
    input  logic       attr_hf_i,
    input  logic       disp_on_i,
    input  logic       hf_flash_i,
    input  logic       phase_i,
    input  logic [1:0] blank_mode_i,
    input  logic       char_dim_i,
    input  logic       blank_grey_i,
    input  logic       bg_on_i,
    input  logic       half_row_i,
    output lvl_e       level_o
);
    logic fg_raw, flash_dark, fg, hilite, area_blank, blank, half;

    always_comb begin
        fg_raw     = in_cell_i & (dot_i ^ attr_rev_i);
        flash_dark = in_cell_i & attr_hf_i & hf_flash_i & ~phase_i;
        fg         = fg_raw & disp_on_i & ~flash_dark;
        hilite     = in_cell_i & attr_hf_i & ~hf_flash_i;
        unique case (blank_mode_i)
            2'd0:    area_blank = 1'b0;
            2'd1:    area_blank = in_cell_i;
            2'd2:    area_blank = in_frame_i;
            default: area_blank = 1'b1;
        endcase
        blank = area_blank | hilite;
        half  = in_frame_i & half_row_i;
        if (fg)         level_o = char_dim_i ? LVL_CHAR_LO : LVL_CHAR_HI;
        else if (blank) level_o = blank_grey_i ? LVL_BLANK_HI : LVL_BLANK_LO;
        else if (half)  level_o = LVL_HALF;
        else if (bg_on_i) level_o = LVL_BGND;
        else            level_o = LVL_PASS;
    end
endmodule

// File: rtl/osd_cell_shader.sv
module osd_cell_shader
    import osd_shade_pkg::*;
#(
    parameter int ROWS        = 12,
    parameter int ROW_W       = 4,
    parameter int FAST_FIELDS = 15,
    parameter int SLOW_FIELDS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              dot_i,
    input  logic              in_cell_i,
    input  logic              in_frame_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic              attr_rev_i,
    input  logic              attr_hf_i,
    input  logic              disp_on_i,
    input  logic              hf_flash_i,
    input  logic              flash_slow_i,
    input  logic [1:0]        blank_mode_i,
    input  logic              char_dim_i,
    input  logic              blank_grey_i,
    input  logic              bg_on_i,
    input  logic              half_wr_i,
    input  logic              half_hi_i,
    input  logic [ROWS/2-1:0] half_data_i,
    output logic [2:0]        level_o
);
    typedef struct packed {
        lvl_e level;
    } out_t;

    out_t st_d, st_q;
    logic phase_w, half_row_w;
    lvl_e pix_w;

    osd_flash_timer #(.FAST_FIELDS(FAST_FIELDS), .SLOW_FIELDS(SLOW_FIELDS)) u_timer (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .slow_i(flash_slow_i), .phase_o(phase_w)
    );

    osd_halftone_mask #(.ROWS(ROWS), .ROW_W(ROW_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(half_wr_i), .hi_i(half_hi_i),
        .data_i(half_data_i), .row_i(row_i), .half_o(half_row_w)
    );

    osd_pixel_resolve u_resolve (
        .dot_i(dot_i), .in_cell_i(in_cell_i), .in_frame_i(in_frame_i),
        .attr_rev_i(attr_rev_i), .attr_hf_i(attr_hf_i), .disp_on_i(disp_on_i),
        .hf_flash_i(hf_flash_i), .phase_i(phase_w), .blank_mode_i(blank_mode_i),
        .char_dim_i(char_dim_i), .blank_grey_i(blank_grey_i), .bg_on_i(bg_on_i),
        .half_row_i(half_row_w), .level_o(pix_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.level = pix_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.level <= LVL_PASS;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;

    a_r9_no_char_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(disp_on_i)) |->
            (level_o != LVL_CHAR_HI && level_o != LVL_CHAR_LO))
        else $error("R9 character level while display off");

    a_r7_full_blank: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blank_mode_i) == 2'd3) |->
            (level_o inside {LVL_CHAR_HI, LVL_CHAR_LO, LVL_BLANK_LO, LVL_BLANK_HI}))
        else $error("R7 full-screen blanking let video through");
endmodule

// File: tb/osd_cell_shader_tb_top.sv
module osd_cell_shader_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync = 0, dot = 0, in_cell = 0, in_frame = 0;
    logic [3:0] row = 0;
    logic rev = 0, hf = 0, disp_on = 0, hf_flash = 0, slow = 0;
    logic [1:0] bmode = 0;
    logic dim = 0, grey = 0, bg_on = 0, hwr = 0, hhi = 0;
    logic [5:0] hdata = 0;
    logic [2:0] level;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [2:0] PASS = 3'd0, CHI = 3'd1, CLO = 3'd2, BLO = 3'd3,
                           BHI = 3'd4, HALF = 3'd5, BGND = 3'd6;

    always #2.5 clk = ~clk;

    osd_cell_shader dut_i (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .dot_i(dot), .in_cell_i(in_cell),
        .in_frame_i(in_frame), .row_i(row), .attr_rev_i(rev), .attr_hf_i(hf),
        .disp_on_i(disp_on), .hf_flash_i(hf_flash), .flash_slow_i(slow),
        .blank_mode_i(bmode), .char_dim_i(dim), .blank_grey_i(grey), .bg_on_i(bg_on),
        .half_wr_i(hwr), .half_hi_i(hhi), .half_data_i(hdata), .level_o(level)
    );

    task automatic check(string req, logic [2:0] exp);
        checks++;
        if (level !== exp) begin
            failures++;
            $display("FAIL %s: level=%0d expected=%0d", req, level, exp);
        end
    endtask

    task automatic idle_inputs();
        vsync = 0; dot = 0; in_cell = 0; in_frame = 0; row = 0; rev = 0; hf = 0;
        disp_on = 1; hf_flash = 0; slow = 0; bmode = 0; dim = 0; grey = 0;
        bg_on = 0; hwr = 0; hhi = 0; hdata = 0;
    endtask

    // apply at a falling edge, let one rising edge register it, sample at the next falling edge
    task automatic pix(logic d, logic c, logic f, string req, logic [2:0] exp);
        @(negedge clk);
        dot = d; in_cell = c; in_frame = f;
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) vsync = 1;
            @(negedge clk) vsync = 0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        dot = 1; in_cell = 1;
        repeat (2) @(negedge clk);
        check("R1 reset holds PASS", PASS);
        rst_n = 1;
        dot = 0; in_cell = 0;
        @(negedge clk);
        check("R1 first cycle after reset", PASS);
        pix(0, 0, 1, "R1 halftone mask clear", PASS);
        hf = 1; hf_flash = 1;
        pix(1, 1, 1, "R1 flash phase starts on", CHI);
    endtask

    task automatic t_basic();
        do_reset();
        pix(1, 1, 1, "R2 dot bright", CHI);
        dim = 1;
        pix(1, 1, 1, "R2 dot dim", CLO);
        pix(0, 1, 1, "R2 cell background passes", PASS);
        pix(1, 0, 1, "R2 outside cell passes", PASS);
    endtask

    task automatic t_reverse();
        do_reset();
        rev = 1;
        pix(1, 1, 1, "R3 reversed dot dark", PASS);
        pix(0, 1, 1, "R3 reversed background lit", CHI);
        pix(0, 0, 1, "R3 reverse ignored outside cell", PASS);
    endtask

    task automatic t_flash_fast();
        do_reset();
        hf = 1; hf_flash = 1;
        pix(1, 1, 1, "R4 flash on at start", CHI);
        pulses(14);
        pix(1, 1, 1, "R4 still on after 14 fields", CHI);
        pulses(1);
        pix(1, 1, 1, "R5 off phase dot to PASS", PASS);
        bmode = 2'd1;
        pix(1, 1, 1, "R5 off phase dot to blank", BLO);
        bmode = 2'd0;
        pulses(15);
        pix(1, 1, 1, "R4 back on after 30 fields", CHI);
    endtask

    task automatic t_flash_slow();
        do_reset();
        hf = 1; hf_flash = 1; slow = 1;
        pulses(29);
        pix(1, 1, 1, "R4 slow still on after 29", CHI);
        pulses(1);
        pix(1, 1, 1, "R4 slow off after 30", PASS);
    endtask

    task automatic t_highlight();
        do_reset();
        hf = 1; hf_flash = 0;
        pulses(15);
        pix(1, 1, 1, "R6 highlight dot ignores flash", CHI);
        pix(0, 1, 1, "R6 highlight background blanked", BLO);
    endtask

    task automatic t_blank();
        do_reset();
        pix(0, 1, 1, "R7 mode0 no blank", PASS);
        bmode = 2'd1;
        pix(0, 1, 1, "R7 mode1 cell blank", BLO);
        pix(0, 0, 1, "R7 mode1 frame untouched", PASS);
        bmode = 2'd2;
        pix(0, 0, 1, "R7 mode2 frame blank", BLO);
        pix(0, 0, 0, "R7 mode2 outside frame", PASS);
        bmode = 2'd3;
        pix(0, 0, 0, "R7 mode3 all blank", BLO);
        pix(1, 1, 1, "R7 mode3 dot stays char", CHI);
        grey = 1;
        pix(0, 0, 0, "R8 grey blanking", BHI);
    endtask

    task automatic t_display_off();
        do_reset();
        disp_on = 0;
        pix(1, 1, 1, "R9 dot hidden when off", PASS);
        bmode = 2'd1;
        pix(1, 1, 1, "R9 blanking still applies", BLO);
    endtask

    task automatic t_halftone();
        do_reset();
        @(negedge clk);
        hwr = 1; hhi = 1; hdata = 6'b000100;
        @(negedge clk);
        hwr = 1; hhi = 0; hdata = 6'b000010;
        @(negedge clk);
        hwr = 0;
        row = 4'd8;
        pix(0, 0, 1, "R10 row 8 halftone", HALF);
        row = 4'd7;
        pix(0, 0, 1, "R10 row 7 no halftone", PASS);
        row = 4'd1;
        pix(0, 0, 1, "R10 row 1 halftone", HALF);
        pix(0, 0, 0, "R10 outside frame", PASS);
        row = 4'd8;
        pix(1, 1, 1, "R10 dot over halftone", CHI);
        @(negedge clk);
        hwr = 1; hhi = 1; hdata = 6'b111111;
        @(negedge clk);
        hwr = 0; row = 4'd12;
        pix(0, 0, 1, "R10 row 12 never halftone", PASS);
        row = 4'd1;
        pix(0, 0, 1, "R10 low half kept", HALF);
    endtask

    task automatic t_background();
        do_reset();
        bg_on = 1;
        pix(0, 0, 0, "R11 background fill", BGND);
        pix(1, 1, 1, "R11 dot over background", CHI);
    endtask

    initial begin
        idle_inputs();
        t_reset();
        t_basic();
        t_reverse();
        t_flash_fast();
        t_flash_slow();
        t_highlight();
        t_blank();
        t_display_off();
        t_halftone();
        t_background();
        done = 1;
    end

    initial begin
        fork
            wait (done == 1);
            begin
                repeat (50000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule